// File: doc/BRIEF.md
# Thresholded Receive FIFO Read Port

This block is the host-facing side of a byte-wide receive queue that holds incoming network frames. On the network side, a producer pushes one byte per cycle and marks the final byte of each frame. On the host side, a 16-bit data register is read one access at a time. Each access carries two active-low byte enables that choose a single-byte or a full-word transfer.

Reads return a data-valid acknowledge only while the queue is open. The queue opens when enough bytes have accumulated: a large fill level, a small one in low-latency mode, or any complete frame held. A request output tells the host that it may start reading. When the request falls, reads that are already under way keep receiving valid data until the queue is empty. The last byte of each frame is reported through an end-of-frame output. An optional byte-swap setting reverses the order of the two bytes in a word.

All responses are registered. The outputs for an access issued in one cycle appear in the next cycle and are held there for one cycle. The queue depth must be a power of two.

Top module: `rxq_read_port`

## Requirements
- R1: `rd_req` is 1 whenever the queue holds at least THRESH_HI (64) bytes. In low-latency mode (`cfg_lowlat`=1) the level is THRESH_LO (12) bytes. `rd_req` reflects the occupancy after the most recent clock edge.
- R2: A read issued before the queue has opened returns `rd_ack`=0 and removes no data.
- R3: Once the queue has opened, it stays open after `rd_req` falls, and reads keep returning `rd_ack`=1 until the queue is empty. A read issued on an empty queue returns `rd_ack`=0.
- R4: Byte enables are active low. `be_n`=2'b10 is a byte read on bits 7:0, and `be_n`=2'b01 is a byte read on bits 15:8. In both cases the other lane reads as zero. `be_n`=2'b11 returns no acknowledge and removes nothing.
- R5: `be_n`=2'b00 is a word read that removes two bytes. With `cfg_swap`=0 the older byte is on bits 7:0 and the newer byte on bits 15:8. With `cfg_swap`=1 the two are reversed.
- R6: A word read whose older byte ends a frame, or that finds only one byte held, removes that one byte only. The lane the second byte would have used reads as zero.
- R7: A write access (`acc_write`=1) returns `rd_ack`=0 and leaves the queue contents unchanged.
- R8: `rd_eof` is 1, together with `rd_ack`, exactly on the response that delivers the last byte of a frame.
- R9: A complete frame that is shorter than the open level still raises `rd_req` and opens the queue.
- R10: The response to an access appears in the cycle after the access. When `rd_ack`=0, `rd_data` is zero.
- R11: A byte pushed while DEPTH (128) bytes are already held is discarded. The bytes already held are unaffected.
- R12: A synchronous reset `rst` empties the queue and clears `rd_req`, `rd_ack` and `rd_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Push one byte from the network side |
| wr_byte | input | 8 | Byte being pushed |
| wr_last | input | 1 | Pushed byte ends a frame |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | Access is a write (ignored) |
| be_n | input | 2 | Active-low byte enables: bit 0 selects lane 7:0, bit 1 selects lane 15:8 |
| cfg_swap | input | 1 | Reverse the byte order of word reads |
| cfg_lowlat | input | 1 | Use the low open level |
| rd_data | output | 16 | Read data, registered |
| rd_ack | output | 1 | Data-valid acknowledge for the previous access |
| rd_eof | output | 1 | Previous access delivered the last byte of a frame |
| rd_req | output | 1 | Read request: open level reached or a complete frame held |

## Verification
Several fill patterns are used. A slow fill that is read early separates a premature acknowledge from a correct refusal. A fill to exactly one byte below the open level and then one byte at the level shows which byte raises the request. A full drain after the request has fallen shows whether the queue stays open until it is empty. Short frames, and frames that end on the older or the newer byte of a word, separate single-byte word reads and end-of-frame placement from ordinary two-byte reads. Swap on and off, both single lanes, no lanes and write accesses are each compared against a byte model. An overfill beyond the depth shows that excess pushes are dropped and the held data is not corrupted.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        LANES_NONE,
        LANES_LO,
        LANES_HI,
        LANES_BOTH
    } rxq_lanes_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  rxq_entry_t    wr_entry,
    input  logic [AW-1:0] rd_addr,
    output rxq_entry_t    rd_first,
    output rxq_entry_t    rd_second
);

    rxq_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_entry;
        end
    end

    // The pointer wraps naturally because the depth is a power of two.
    assign rd_first  = mem[rd_addr];
    assign rd_second = mem[rd_addr + AW'(1)];

endmodule

// File: rtl/rxq_lane.sv
module rxq_lane
    import rxq_pkg::*;
#(
    parameter int CW = 8
) (
    input  rxq_entry_t    first,
    input  rxq_entry_t    second,
    input  logic [CW-1:0] occ,
    input  logic [1:0]    be_n,
    input  logic          swap,
    input  logic          grant,
    output logic [15:0]   data,
    output logic [1:0]    take,
    output logic          eof,
    output logic          ack
);

    rxq_lanes_t lanes;
    logic       two_ok;
    logic [7:0] hi_byte;

    always_comb begin
        unique case (be_n)
            2'b00:   lanes = LANES_BOTH;
            2'b10:   lanes = LANES_LO;
            2'b01:   lanes = LANES_HI;
            default: lanes = LANES_NONE;
        endcase
    end

    always_comb begin
        two_ok  = !first.last && (occ >= CW'(2));
        hi_byte = two_ok ? second.data : 8'h00;
        ack     = grant && (lanes != LANES_NONE);
        data    = 16'h0000;
        take    = 2'd0;
        eof     = 1'b0;
        if (ack) begin
            unique case (lanes)
                LANES_LO: begin
                    data = {8'h00, first.data};
                    take = 2'd1;
                    eof  = first.last;
                end
                LANES_HI: begin
                    data = {first.data, 8'h00};
                    take = 2'd1;
                    eof  = first.last;
                end
                default: begin
                    data = swap ? {first.data, hi_byte} : {hi_byte, first.data};
                    take = two_ok ? 2'd2 : 2'd1;
                    eof  = two_ok ? second.last : first.last;
                end
            endcase
        end
    end

endmodule

// File: rtl/rxq_gate.sv
module rxq_gate #(
    parameter int CW        = 8,
    parameter int THRESH_HI = 64,
    parameter int THRESH_LO = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lowlat,
    input  logic [CW-1:0] occ_d,
    input  logic [CW-1:0] frames_d,
    output logic          req_q,
    output logic          open_q
);

    typedef struct packed {
        logic req;
        logic open;
    } gate_t;

    gate_t         g_d, g_q;
    logic [CW-1:0] level;

    always_comb begin
        level     = lowlat ? CW'(THRESH_LO) : CW'(THRESH_HI);
        g_d.req   = (occ_d >= level) || (frames_d != '0);
        if (g_d.req) begin
            g_d.open = 1'b1;
        end else if (occ_d == '0) begin
            g_d.open = 1'b0;
        end else begin
            g_d.open = g_q.open;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign req_q  = g_q.req;
    assign open_q = g_q.open;

endmodule

// File: rtl/rxq_read_port.sv
module rxq_read_port
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int THRESH_HI = 64,
    parameter int THRESH_LO = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [7:0]  wr_byte,
    input  logic        wr_last,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  be_n,
    input  logic        cfg_swap,
    input  logic        cfg_lowlat,
    output logic [15:0] rd_data,
    output logic        rd_ack,
    output logic        rd_eof,
    output logic        rd_req
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] occ;
        logic [CW-1:0] frames;
        logic [15:0]   data;
        logic          ack;
        logic          eof;
    } state_t;

    state_t        st_d, st_q;
    rxq_entry_t    ent_first, ent_second, ent_in;
    logic          push_ok, grant, gate_open;
    logic [15:0]   lane_data;
    logic [1:0]    lane_take;
    logic          lane_eof, lane_ack;
    logic [CW-1:0] occ_now;

    assign ent_in  = '{data: wr_byte, last: wr_last};
    assign push_ok = wr_valid && (st_q.occ < CW'(DEPTH));
    assign grant   = acc_valid && !acc_write && gate_open;
    assign occ_now = st_q.occ;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en     (push_ok),
        .wr_addr   (st_q.wr_ptr),
        .wr_entry  (ent_in),
        .rd_addr   (st_q.rd_ptr),
        .rd_first  (ent_first),
        .rd_second (ent_second)
    );

    rxq_lane #(.CW(CW)) u_lane (
        .first  (ent_first),
        .second (ent_second),
        .occ    (st_q.occ),
        .be_n   (be_n),
        .swap   (cfg_swap),
        .grant  (grant),
        .data   (lane_data),
        .take   (lane_take),
        .eof    (lane_eof),
        .ack    (lane_ack)
    );

    always_comb begin
        st_d        = st_q;
        st_d.wr_ptr = st_q.wr_ptr + AW'(push_ok);
        st_d.rd_ptr = st_q.rd_ptr + AW'(lane_take);
        st_d.occ    = st_q.occ + CW'(push_ok) - CW'(lane_take);
        st_d.frames = st_q.frames + CW'(push_ok && wr_last) - CW'(lane_ack && lane_eof);
        st_d.data   = lane_data;
        st_d.ack    = lane_ack;
        st_d.eof    = lane_eof;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rxq_gate #(
        .CW        (CW),
        .THRESH_HI (THRESH_HI),
        .THRESH_LO (THRESH_LO)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .lowlat   (cfg_lowlat),
        .occ_d    (st_d.occ),
        .frames_d (st_d.frames),
        .req_q    (rd_req),
        .open_q   (gate_open)
    );

    assign rd_data = st_q.data;
    assign rd_ack  = st_q.ack;
    assign rd_eof  = st_q.eof;

endmodule

// File: rtl/rxq_read_port_chk.sv
module rxq_read_port_chk #(
    parameter int DEPTH     = 128,
    parameter int THRESH_HI = 64,
    parameter int CW        = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [1:0]    be_n,
    input logic          rd_ack,
    input logic          rd_eof,
    input logic          rd_req,
    input logic          open_q,
    input logic [CW-1:0] occ_q
);

    p_level_req_r1: assert property (@(posedge clk) disable iff (rst)
        (occ_q >= CW'(THRESH_HI)) |-> rd_req);

    p_closed_no_ack_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !open_q) |=> !rd_ack);

    p_open_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        open_q |-> (occ_q != '0));

    p_no_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && be_n == 2'b11) |=> !rd_ack);

    p_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> !rd_ack);

    p_eof_with_ack_r8: assert property (@(posedge clk) disable iff (rst)
        rd_eof |-> rd_ack);

    p_bounded_r11: assert property (@(posedge clk) disable iff (rst)
        occ_q <= CW'(DEPTH));

endmodule

bind rxq_read_port rxq_read_port_chk #(
    .DEPTH     (DEPTH),
    .THRESH_HI (THRESH_HI),
    .CW        (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .be_n      (be_n),
    .rd_ack    (rd_ack),
    .rd_eof    (rd_eof),
    .rd_req    (rd_req),
    .open_q    (gate_open),
    .occ_q     (occ_now)
);

// File: tb/rxq_read_port_test.sv
module rxq_read_port_test;

    localparam int DEPTH = 128;
    localparam int HI    = 64;
    localparam int LO    = 12;

    logic        clk = 1'b0;
    logic        rst, wr_valid, wr_last, acc_valid, acc_write, cfg_swap, cfg_lowlat;
    logic [7:0]  wr_byte;
    logic [1:0]  be_n;
    logic [15:0] rd_data;
    logic        rd_ack, rd_eof, rd_req;

    always #5 clk = ~clk;

    rxq_read_port uut (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .wr_last    (wr_last),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .be_n       (be_n),
        .cfg_swap   (cfg_swap),
        .cfg_lowlat (cfg_lowlat),
        .rd_data    (rd_data),
        .rd_ack     (rd_ack),
        .rd_eof     (rd_eof),
        .rd_req     (rd_req)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic [8:0]  mq[$];
    int          mframes = 0;
    bit          mopen   = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];
    bit          was_acc;

    function automatic void model_settle();
        int thr;
        thr = cfg_lowlat ? LO : HI;
        if (mq.size() >= thr || mframes > 0) mopen = 1;
        else if (mq.size() == 0)             mopen = 0;
    endfunction

    task automatic push(input logic [7:0] b, input bit last);
        wr_valid = 1; wr_byte = b; wr_last = last;
        @(negedge clk);
        wr_valid = 0; wr_last = 0;
        if (mq.size() < DEPTH) begin
            mq.push_back({last, b});
            if (last) mframes++;
        end
        model_settle();
    endtask

    task automatic access(input bit wr, input logic [1:0] be, input string tag);
        logic [15:0] d = 16'h0;
        bit          a = 0, e = 0;
        logic [8:0]  f, s;
        if (!wr && mopen && be != 2'b11 && mq.size() > 0) begin
            a = 1;
            f = mq.pop_front();
            if (f[8]) mframes--;
            case (be)
                2'b10: begin d = {8'h00, f[7:0]}; e = f[8]; end
                2'b01: begin d = {f[7:0], 8'h00}; e = f[8]; end
                default: begin
                    if (!f[8] && mq.size() > 0) begin
                        s = mq.pop_front();
                        if (s[8]) mframes--;
                        e = s[8];
                        d = cfg_swap ? {f[7:0], s[7:0]} : {s[7:0], f[7:0]};
                    end else begin
                        e = f[8];
                        d = cfg_swap ? {f[7:0], 8'h00} : {8'h00, f[7:0]};
                    end
                end
            endcase
        end
        exp_q.push_back({a, e, d});
        tag_q.push_back(tag);
        acc_valid = 1; acc_write = wr; be_n = be;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; be_n = 2'b00;
        model_settle();
    endtask

    task automatic check_req(input bit exp, input string tag);
        checks++;
        if (rd_req !== exp) begin
            fails++;
            $display("FAIL %s: rd_req=%0b expected %0b", tag, rd_req, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        mq.delete(); mframes = 0; mopen = 0;
    endtask

    task automatic drain(input string tag);
        while (mq.size() > 0) access(0, 2'b00, tag);
    endtask

    // Monitor: compares each response with the oldest expected item.
    initial begin
        logic [17:0] ex;
        string       t;
        forever begin
            @(posedge clk);
            was_acc = acc_valid;
            @(negedge clk);
            if (was_acc) begin
                ex = exp_q.pop_front();
                t  = tag_q.pop_front();
                checks++;
                if ({rd_ack, rd_eof, rd_data} !== ex) begin
                    fails++;
                    $display("FAIL %s: ack=%0b eof=%0b data=%h expected ack=%0b eof=%0b data=%h",
                             t, rd_ack, rd_eof, rd_data, ex[17], ex[16], ex[15:0]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_valid = 0; wr_last = 0; wr_byte = 0;
        acc_valid = 0; acc_write = 0; be_n = 2'b00;
        cfg_swap = 0; cfg_lowlat = 0;
        @(negedge clk);
        do_reset();

        // R12: reset state
        checks++;
        if (rd_req !== 0 || rd_ack !== 0 || rd_eof !== 0) begin
            fails++;
            $display("FAIL R12 reset: req=%0b ack=%0b eof=%0b expected 0 0 0", rd_req, rd_ack, rd_eof);
        end

        // R2 / R10: early read gets no acknowledge and zero data
        for (int i = 0; i < 10; i++) push(8'h10 + 8'(i), 0);
        access(0, 2'b00, "R2 R10 early read");
        check_req(0, "R2 below level");

        // R1: request raised by the 64th byte
        for (int i = 10; i < 63; i++) push(8'h10 + 8'(i), 0);
        check_req(0, "R1 63 bytes");
        push(8'h4F, 0);
        check_req(1, "R1 64 bytes");

        // R5: word order, then swapped
        access(0, 2'b00, "R5 word plain");
        check_req(0, "R3 request falls below level");
        access(0, 2'b00, "R5 word plain 2");
        cfg_swap = 1;
        access(0, 2'b00, "R5 word swapped");
        access(0, 2'b00, "R5 word swapped 2");
        cfg_swap = 0;

        // R4: single lanes and no lanes
        access(0, 2'b10, "R4 low lane");
        access(0, 2'b01, "R4 high lane");
        access(0, 2'b11, "R4 no lanes");

        // R7: write ignored, next read shows the same byte
        access(1, 2'b00, "R7 write access");
        access(0, 2'b10, "R7 data unchanged after write");

        // R3: keep draining after the request dropped, then empty read
        drain("R3 drain");
        access(0, 2'b00, "R3 empty read");
        check_req(0, "R3 empty");

        // R9 / R6 / R8: short frame of 5 bytes
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i), i == 4);
        check_req(1, "R9 short frame");
        access(0, 2'b00, "R9 word 1");
        access(0, 2'b00, "R9 word 2");
        access(0, 2'b00, "R6 R8 single byte end");
        access(0, 2'b00, "R3 read after frame drained");

        // R6 / R8: frames ending on either byte of a word
        for (int i = 0; i < 3; i++) push(8'hB0 + 8'(i), i == 2);
        for (int i = 0; i < 2; i++) push(8'hC0 + 8'(i), i == 1);
        cfg_swap = 1;
        access(0, 2'b00, "R8 frame A word");
        access(0, 2'b00, "R6 frame A tail");
        access(0, 2'b00, "R8 frame B end on second byte");
        cfg_swap = 0;

        // R1: low-latency level
        cfg_lowlat = 1;
        for (int i = 0; i < 11; i++) push(8'hD0 + 8'(i), 0);
        check_req(0, "R1 lowlat 11 bytes");
        push(8'hDB, 0);
        check_req(1, "R1 lowlat 12 bytes");
        drain("R1 lowlat drain");
        cfg_lowlat = 0;

        // R12: reset in the middle of a fill
        for (int i = 0; i < 70; i++) push(8'(i), 0);
        check_req(1, "R12 before reset");
        do_reset();
        check_req(0, "R12 after reset");
        access(0, 2'b00, "R12 read after reset");

        // R11: overfill, excess dropped
        for (int i = 0; i < 130; i++) push(8'(i) ^ 8'h5A, 0);
        check_req(1, "R11 full");
        drain("R11 drain after overfill");
        access(0, 2'b00, "R11 empty after drain");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule